// File: doc/BRIEF.md
# Quad Serial DAC Input Register

This block is the digital front end of a four-channel, 6-bit DAC. A host loads the four codes over a three-wire serial link: a data line, a shift clock and an active-low enable. While enable is low, each falling edge of the shift clock pushes one data bit into a 24-bit shift register. When enable goes high again, the whole register is copied into a holding stage. That holding stage drives the four parallel codes that feed the resistor ladders.

The block runs on a fast system clock. It oversamples the three serial pins through a synchronizer and finds shift-clock falls and enable rises from the synchronized levels. A gate bit stands in for the transparent latch in the clock path. The gate follows enable only while the shift clock is high, so a fall can shift only when enable was low during the preceding high phase.

The bit that leaves the register comes out on a serial output, so several stages can be daisy-chained. Only the last 24 bits of a load count. Any earlier bits pass through the register and out of the cascade output.

Top module: `quad_dac_input_reg`

## Requirements
- R1: While `rst_ni` is low, `codes_o` and `sdout_o` are all zeros.
- R2: The shift register advances by one bit on each synchronized falling edge of `sclk_i`, and never on a rising edge.
- R3: Data enters MSB first. After a load, the last 6-bit word shifted sits on channel 1 (`codes_o[5:0]`), the word before it on channel 2 (`codes_o[11:6]`), then channel 3 (`codes_o[17:12]`), and the first of the four words on channel 4 (`codes_o[23:18]`).
- R4: `codes_o` changes only on a synchronized low-to-high transition of `en_ni`. At that transition it takes the shift register contents. Shifting alone never alters it.
- R5: A shift-clock fall has no effect when `en_ni` was high during the preceding high phase of `sclk_i`.
- R6: When more than 24 bits are shifted before a load, only the last 24 bits determine `codes_o`.
- R7: `sdout_o` equals the bit that was shifted in 24 shifts earlier, which is the oldest bit held in the register. It changes only on a shift.
- R8: If a shift-clock fall and an enable rise reach the block in the same cycle, the shift still happens (enable was low during the high phase), and the transfer includes that final bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock; shifting happens on its falling edge |
| en_ni | input | 1 | Active-low load enable; its rising edge transfers the frame |
| sdata_i | input | 1 | Serial data input, MSB first |
| sdout_o | output | 1 | Cascade output, the bit leaving the 24-bit register |
| codes_o | output | 24 | Four 6-bit channel codes, channel 1 in the low bits |

## Verification
A shift and a transfer can happen in the same system-clock cycle. This is the case when the last shift-clock fall and the rising edge of enable are driven on the same bench edge, so both pass through the synchronizer together. The bench shifts 23 bits, raises the shift clock with the 24th bit, then drops the shift clock and raises enable at once. The captured codes must contain all 24 bits, which shows the final shift was not lost. A cycle-accurate behavioural model is also compared on every clock, and it checks the alignment of that collision cycle.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned DEF_CH_NUM      = 4;
  localparam int unsigned DEF_CODE_W      = 6;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic sdata;
    logic en_n;
    logic sclk;
  } ser_pins_t;

  localparam ser_pins_t PINS_IDLE = '{sdata: 1'b0, en_n: 1'b1, sclk: 1'b0};
endpackage

// File: rtl/qdi_sync.sv
module qdi_sync #(
  parameter int unsigned          W       = 3,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdi_edge_gate.sv
module qdi_edge_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic en_n_s_i,
  output logic shift_o,
  output logic load_o
);
  logic sclk_d_q, en_d_q, gate_q;

  // gate follows enable only while sclk is high, like a transparent latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      en_d_q   <= 1'b1;
      gate_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s_i;
      en_d_q   <= en_n_s_i;
      if (sclk_s_i) gate_q <= ~en_n_s_i;
    end
  end

  assign shift_o = sclk_d_q & ~sclk_s_i & gate_q;
  assign load_o  = en_n_s_i & ~en_d_q;

  // R2
  no_shift_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> $past(sclk_s_i) && !sclk_s_i);
endmodule

// File: rtl/qdi_shift_reg.sv
module qdi_shift_reg #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               sdata_i,
  output logic [FRAME_W-1:0] sr_next_o,
  output logic               sdout_o
);
  logic [FRAME_W-1:0] sr_q;

  assign sr_next_o = shift_i ? {sr_q[FRAME_W-2:0], sdata_i} : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_next_o;
  end

  assign sdout_o = sr_q[FRAME_W-1];

  // R7
  sdout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sdout_o));
endmodule

// File: rtl/qdi_hold_latch.sv
module qdi_hold_latch #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned FRAME_W = CH_NUM * CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] codes_o
);
  generate
    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     code_q <= '0;
        else if (load_i) code_q <= frame_i[ch*CODE_W +: CODE_W];
      end
      assign codes_o[ch*CODE_W +: CODE_W] = code_q;
    end
  endgenerate

  // R4
  codes_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(codes_o));
endmodule

// File: rtl/quad_dac_input_reg.sv
module quad_dac_input_reg
  import quad_dac_pkg::*;
#(
  parameter int unsigned CH_NUM      = DEF_CH_NUM,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned FRAME_W    = CH_NUM * CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               en_ni,
  input  logic               sdata_i,
  output logic               sdout_o,
  output logic [FRAME_W-1:0] codes_o
);
  ser_pins_t          pins_raw, pins_s;
  logic               shift, load;
  logic [FRAME_W-1:0] sr_next;

  assign pins_raw = '{sdata: sdata_i, en_n: en_ni, sclk: sclk_i};

  qdi_sync #(
    .W($bits(ser_pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  qdi_edge_gate u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_s_i(pins_s.sclk), .en_n_s_i(pins_s.en_n),
    .shift_o(shift), .load_o(load)
  );

  qdi_shift_reg #(.FRAME_W(FRAME_W)) u_sr (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift), .sdata_i(pins_s.sdata),
    .sr_next_o(sr_next), .sdout_o(sdout_o)
  );

  qdi_hold_latch #(.CH_NUM(CH_NUM), .CODE_W(CODE_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .frame_i(sr_next),
    .codes_o(codes_o)
  );

  // R5
  en_blocks_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift |-> !$past(pins_s.en_n));

  // R8
  collide_bit_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && load) |=> codes_o[0] == $past(pins_s.sdata));
endmodule

// File: tb/quad_dac_input_reg_test.sv
module quad_dac_input_reg_test;
  localparam int S  = 2;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, en_n = 1'b1, sdata = 1'b0;
  logic sdout;
  logic [23:0] codes;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_dac_input_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .en_ni(en_n),
    .sdata_i(sdata), .sdout_o(sdout), .codes_o(codes)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: pin samples delayed by S, then edge rules
  logic [2:0] pipe[$];
  logic       m_sclk_d, m_en_d, m_gate;
  logic [23:0] m_sr, m_codes;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe = {};
      for (int i = 0; i < S; i++) pipe.push_front(3'b010);
      m_sclk_d = 0; m_en_d = 1; m_gate = 0; m_sr = '0; m_codes = '0;
    end else begin
      logic [2:0] cur;
      bit fall, ld;
      cur = pipe[$];
      void'(pipe.pop_back());
      pipe.push_front({sdata, en_n, sclk});
      fall = m_sclk_d && !cur[0];
      ld   = cur[1] && !m_en_d;
      if (fall && m_gate) m_sr = {m_sr[22:0], cur[2]};
      if (ld) m_codes = m_sr;
      if (cur[0]) m_gate = !cur[1];
      m_sclk_d = cur[0];
      m_en_d   = cur[1];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(codes == m_codes, "R2 model codes", {8'h0, codes}, {8'h0, m_codes});
      check(sdout == m_sr[23], "R7 model sdout", {31'h0, sdout}, {31'h0, m_sr[23]});
    end
  end

  task automatic clk_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    repeat (PH) @(negedge clk);
    sclk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic en_low();
    @(negedge clk); en_n = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic en_high();
    @(negedge clk); en_n = 1'b1;
    repeat (PH + 4) @(negedge clk);
  endtask

  function automatic logic [23:0] frame(input logic [5:0] c4, c3, c2, c1);
    return {c4, c3, c2, c1};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] fa, fb, fc;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check(codes == '0, "R1 codes in reset", {8'h0, codes}, 0);
    check(sdout == 1'b0, "R1 sdout in reset", {31'h0, sdout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: word order, R4: no change before enable rise
    fa = frame(6'h2A, 6'h15, 6'h3C, 6'h07);
    en_low();
    send(fa, 24);
    check(codes == '0, "R4 codes before load", {8'h0, codes}, 0);
    en_high();
    check(codes == fa, "R3 channel mapping", {8'h0, codes}, {8'h0, fa});
    check(codes[5:0] == 6'h07, "R3 channel 1 is last word", {26'h0, codes[5:0]}, 32'h07);
    check(codes[23:18] == 6'h2A, "R3 channel 4 is first word", {26'h0, codes[23:18]}, 32'h2A);
    check(sdout == fa[23], "R7 sdout after full frame", {31'h0, sdout}, {31'h0, fa[23]});

    // R5: falls with enable high are ignored
    for (int i = 0; i < 5; i++) clk_bit(1'b1);
    check(sdout == fa[23], "R5 sdout unchanged, enable high", {31'h0, sdout}, {31'h0, fa[23]});
    en_low();
    en_high();
    check(codes == fa, "R5 reload after blocked clocks", {8'h0, codes}, {8'h0, fa});

    // R6: leading extra bits drop off
    fb = frame(6'h01, 6'h3F, 6'h20, 6'h11);
    en_low();
    send(24'hFFFFFF, 6);
    send(fb, 24);
    en_high();
    check(codes == fb, "R6 extra leading bits ignored", {8'h0, codes}, {8'h0, fb});

    // R7: cascade output carries old frame MSB first; R4 codes held
    fc = frame(6'h33, 6'h0C, 6'h2D, 6'h12);
    en_low();
    for (int n = 0; n < 24; n++) begin
      check(sdout == fb[23-n], "R7 sdout cascade bit", {31'h0, sdout}, {31'h0, fb[23-n]});
      clk_bit(fc[23-n]);
    end
    check(sdout == fc[23], "R7 sdout after new frame", {31'h0, sdout}, {31'h0, fc[23]});
    check(codes == fb, "R4 codes held while shifting", {8'h0, codes}, {8'h0, fb});
    en_high();
    check(codes == fc, "R4 transfer on enable rise", {8'h0, codes}, {8'h0, fc});

    // R8: last fall and enable rise in the same cycle
    fa = frame(6'h0F, 6'h30, 6'h05, 6'h29);
    en_low();
    send(fa >> 1, 23);
    @(negedge clk); sdata = fa[0]; sclk = 1'b1;
    repeat (PH) @(negedge clk);
    sclk = 1'b0; en_n = 1'b1;
    repeat (PH + 4) @(negedge clk);
    check(codes == fa, "R8 collision keeps final bit", {8'h0, codes}, {8'h0, fa});

    // R1: asynchronous reset clears outputs
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(codes == '0, "R1 async reset codes", {8'h0, codes}, 0);
    check(sdout == 1'b0, "R1 async reset sdout", {31'h0, sdout}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule